// File: doc/BRIEF.md
# Dual-mode saturating integer multiplier

This block multiplies two N-bit integers and returns an N-bit result that never wraps around. A single mode input says whether both operands are unsigned or two's complement. When the true product does not fit in N bits for the chosen mode, the result is pinned to the nearest representable extreme and an overflow flag is raised.

The datapath is purely combinational and has no clock. Its carry-save array forms only the N+1 low-order bits of the product. A separate overflow unit runs beside the array and judges from the operands whether clamping is needed. It measures how many significant bits each operand carries, and where that count alone cannot settle the question, it consults the top two bits of the truncated product. No upper half of a 2N-bit product exists anywhere in the hardware.

Top module: `sat_mul_dual`

## Requirements
- R1: With signed_mode = 0 and a true product below 2^N, product equals the exact product and overflow is 0.
- R2: With signed_mode = 0 and a true product of 2^N or more, product is all ones and overflow is 1.
- R3: With signed_mode = 1 and a true product within [-2^(N-1), 2^(N-1)-1], product equals the exact two's complement product and overflow is 0.
- R4: With signed_mode = 1 and a true product above 2^(N-1)-1, product is bit N-1 = 0 with all lower bits 1, and overflow is 1.
- R5: With signed_mode = 1 and a true product below -2^(N-1), product is bit N-1 = 1 with all lower bits 0, and overflow is 1.
- R6: If either operand is zero, product is zero and overflow is 0 in both modes, whatever the other operand is.
- R7: With signed_mode = 1, the most negative value times -1 gives the most positive value with overflow 1. The most negative value times +1 gives the most negative value with overflow 0.
- R8: overflow is 1 exactly when the true product lies outside the range of the active mode (signed_mode = 1: two's complement; signed_mode = 0: unsigned).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | First operand |
| opb | input | N | Second operand |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned operands |
| product | output | N | Saturated product |
| overflow | output | 1 | High when the product was clamped |

## Verification
The bench builds the block twice. One copy uses N = 4, which is small enough to run every operand pair in both modes, so every case of the width-sum rule and every saturation direction is reached. The other copy uses N = 16. Random operands are biased toward sizes whose significant-bit counts add up to N+1, N+2 and N+3, which are the thresholds where the overflow unit switches from operand widths to product bits. That copy also gets directed cases at the extreme values.

// File: rtl/sat_mul_pkg.sv
package sat_mul_pkg;

  typedef enum logic {
    MUL_UNSIGNED = 1'b0,
    MUL_SIGNED   = 1'b1
  } mul_mode_e;

  // bits needed for a significant-width count that can reach n+1
  function automatic int width_cnt_bits(int n);
    return $clog2(n + 2);
  endfunction

  // bits needed for the sum of two such counts
  function automatic int width_sum_bits(int n);
    return $clog2(2 * n + 4);
  endfunction

endpackage

// File: rtl/sat_mul_sig_width.sv
// Significant width of one operand.
// Unsigned: bits up to and including the top one.
// Signed: smallest two's complement width that holds the value.
module sat_mul_sig_width #(
  parameter int N  = 8,
  parameter int CW = sat_mul_pkg::width_cnt_bits(N)
) (
  input  logic [N-1:0]  val,
  input  logic          sign_mode,
  output logic [CW-1:0] width
);

  logic          ref_bit;
  logic [CW-1:0] run_cnt;
  logic          running;

  always_comb begin
    ref_bit = sign_mode & val[N-1];
    run_cnt = '0;
    running = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      if (running && (val[i] == ref_bit)) begin
        run_cnt = run_cnt + CW'(1);
      end else begin
        running = 1'b0;
      end
    end
    width = CW'(N) - run_cnt + CW'(sign_mode);
  end

endmodule

// File: rtl/sat_mul_trunc_array.sv
// Carry-save array that keeps only the W low-order product bits.
module sat_mul_trunc_array #(
  parameter int W = 9
) (
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic [W-1:0] low_prod
);

  logic [W-1:0] pp_row  [W];
  logic [W-1:0] sum_row [W];
  logic [W-1:0] cry_row [W];

  for (genvar r = 0; r < W; r++) begin : g_pp
    assign pp_row[r] = mplier[r] ? (mcand << r) : '0;
  end

  assign sum_row[0] = pp_row[0];
  assign cry_row[0] = '0;

  for (genvar r = 1; r < W; r++) begin : g_csa
    logic [W-2:0] maj;
    assign maj = (sum_row[r-1][W-2:0] & cry_row[r-1][W-2:0])
               | (sum_row[r-1][W-2:0] & pp_row[r][W-2:0])
               | (cry_row[r-1][W-2:0] & pp_row[r][W-2:0]);
    assign sum_row[r] = sum_row[r-1] ^ cry_row[r-1] ^ pp_row[r];
    assign cry_row[r] = {maj, 1'b0};
  end

  assign low_prod = sum_row[W-1] + cry_row[W-1];

endmodule

// File: rtl/sat_mul_ovf_detect.sv
// Decides saturation from operand widths plus the two top bits of the
// truncated product.
module sat_mul_ovf_detect #(
  parameter int N  = 8,
  parameter int CW = sat_mul_pkg::width_cnt_bits(N),
  parameter int SW = sat_mul_pkg::width_sum_bits(N)
) (
  input  logic [CW-1:0] width_a,
  input  logic [CW-1:0] width_b,
  input  logic          sign_mode,
  input  logic          prod_top,
  input  logic          prod_next,
  output logic          ovf
);

  localparam logic [SW-1:0] USUM_EDGE = SW'(N + 1);
  localparam logic [SW-1:0] USUM_SURE = SW'(N + 2);
  localparam logic [SW-1:0] SSUM_SURE = SW'(N + 3);

  logic [SW-1:0] wsum;
  logic          ovf_u;
  logic          ovf_s;

  always_comb begin
    wsum  = SW'(width_a) + SW'(width_b);
    ovf_u = (wsum >= USUM_SURE) | ((wsum == USUM_EDGE) & prod_top);
    ovf_s = (wsum >= SSUM_SURE) | (prod_top ^ prod_next);
    ovf   = sign_mode ? ovf_s : ovf_u;
  end

endmodule

// File: rtl/sat_mul_clamp.sv
module sat_mul_clamp #(
  parameter int N = 8
) (
  input  logic [N-1:0] low_prod,
  input  logic         sign_mode,
  input  logic         ovf,
  input  logic         neg_dir,
  output logic [N-1:0] result
);

  logic [N-1:0] sat_val;

  always_comb begin
    if (sign_mode) begin
      sat_val = {neg_dir, {(N-1){~neg_dir}}};
    end else begin
      sat_val = '1;
    end
    result = ovf ? sat_val : low_prod;
  end

endmodule

// File: rtl/sat_mul_dual.sv
module sat_mul_dual #(
  parameter int N = 8
) (
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic         signed_mode,
  output logic [N-1:0] product,
  output logic         overflow
);

  import sat_mul_pkg::*;

  localparam int W  = N + 1;
  localparam int CW = width_cnt_bits(N);
  localparam int SW = width_sum_bits(N);

  mul_mode_e     mode;
  logic [W-1:0]  a_ext;
  logic [W-1:0]  b_ext;
  logic [W-1:0]  low_prod;
  logic [CW-1:0] width_a;
  logic [CW-1:0] width_b;
  logic          ovf;
  logic          neg_dir;

  assign mode    = mul_mode_e'(signed_mode);
  assign a_ext   = {(mode == MUL_SIGNED) & opa[N-1], opa};
  assign b_ext   = {(mode == MUL_SIGNED) & opb[N-1], opb};
  assign neg_dir = opa[N-1] ^ opb[N-1];

  sat_mul_trunc_array #(.W(W)) u_array (
    .mcand    (a_ext),
    .mplier   (b_ext),
    .low_prod (low_prod)
  );

  sat_mul_sig_width #(.N(N), .CW(CW)) u_width_a (
    .val       (opa),
    .sign_mode (signed_mode),
    .width     (width_a)
  );

  sat_mul_sig_width #(.N(N), .CW(CW)) u_width_b (
    .val       (opb),
    .sign_mode (signed_mode),
    .width     (width_b)
  );

  sat_mul_ovf_detect #(.N(N), .CW(CW), .SW(SW)) u_ovf (
    .width_a   (width_a),
    .width_b   (width_b),
    .sign_mode (signed_mode),
    .prod_top  (low_prod[N]),
    .prod_next (low_prod[N-1]),
    .ovf       (ovf)
  );

  sat_mul_clamp #(.N(N)) u_clamp (
    .low_prod  (low_prod[N-1:0]),
    .sign_mode (signed_mode),
    .ovf       (ovf),
    .neg_dir   (neg_dir),
    .result    (product)
  );

  assign overflow = ovf;

endmodule

// File: rtl/sat_mul_dual_chk.sv
module sat_mul_dual_chk #(
  parameter int N = 8
) (
  input logic [N-1:0] opa,
  input logic [N-1:0] opb,
  input logic         signed_mode,
  input logic [N-1:0] product,
  input logic         overflow
);

  localparam int W2 = 2 * N + 2;

  logic [W2-1:0] a_full;
  logic [W2-1:0] b_full;
  logic [W2-1:0] full;
  logic          fits;
  logic          neg;

  always_comb begin
    a_full = signed_mode ? {{(N+2){opa[N-1]}}, opa} : {{(N+2){1'b0}}, opa};
    b_full = signed_mode ? {{(N+2){opb[N-1]}}, opb} : {{(N+2){1'b0}}, opb};
    full   = a_full * b_full;
    neg    = full[W2-1];
    fits   = signed_mode ? ((&full[W2-1:N-1]) | ~(|full[W2-1:N-1]))
                         : ~(|full[W2-1:N]);

    assert_flag_range_R8: assert (overflow == !fits)
      else $error("R8 flag %0b for product %0h", overflow, full);
    // R1 and R3: exact result whenever the true product fits
    assert_exact_in_range_R1: assert (!fits || product == full[N-1:0])
      else $error("R1/R3 in-range mismatch");
    assert_unsigned_sat_R2: assert (signed_mode || !overflow || product == '1)
      else $error("R2 unsigned saturation value");
    assert_signed_pos_sat_R4: assert (!(signed_mode && overflow && !neg)
                                      || product == {1'b0, {(N-1){1'b1}}})
      else $error("R4 positive saturation value");
    assert_signed_neg_sat_R5: assert (!(signed_mode && overflow && neg)
                                      || product == {1'b1, {(N-1){1'b0}}})
      else $error("R5 negative saturation value");
    assert_zero_operand_R6: assert (!(opa == '0 || opb == '0)
                                    || (!overflow && product == '0))
      else $error("R6 zero operand");
    assert_min_neg_one_R7: assert (!(signed_mode && opa == {1'b1, {(N-1){1'b0}}}
                                     && opb == '1)
                                   || (overflow && product == {1'b0, {(N-1){1'b1}}}))
      else $error("R7 most negative times -1");
  end

endmodule

bind sat_mul_dual sat_mul_dual_chk #(.N(N)) u_chk (
  .opa         (opa),
  .opb         (opb),
  .signed_mode (signed_mode),
  .product     (product),
  .overflow    (overflow)
);

// File: tb/sat_mul_dual_tb.sv
module sat_mul_dual_tb_top;

  localparam int NB = 16;
  localparam int NS = 4;

  logic clk;
  logic rst_n;
  int   checks;
  int   errors;
  bit   done;

  logic [NB-1:0] a_b, b_b, p_b;
  logic          m_b, o_b;
  logic [NS-1:0] a_s, b_s, p_s;
  logic          m_s, o_s;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  sat_mul_dual #(.N(NB)) dut_i (
    .opa(a_b), .opb(b_b), .signed_mode(m_b), .product(p_b), .overflow(o_b)
  );

  sat_mul_dual #(.N(NS)) dut_small_i (
    .opa(a_s), .opb(b_s), .signed_mode(m_s), .product(p_s), .overflow(o_s)
  );

  // returns {ovf, result}
  function automatic logic [32:0] ref_sat(int n, bit md, longint a, longint b);
    longint av, bv, p, hi, lo, mask;
    logic [31:0] r;
    logic ov;
    mask = (longint'(1) << n) - 1;
    av = (md && a[n-1]) ? a - (longint'(1) << n) : a;
    bv = (md && b[n-1]) ? b - (longint'(1) << n) : b;
    p  = av * bv;
    hi = md ? (longint'(1) << (n - 1)) - 1 : mask;
    lo = md ? -(longint'(1) << (n - 1)) : 0;
    if (p > hi) begin
      ov = 1'b1; r = 32'(hi & mask);
    end else if (p < lo) begin
      ov = 1'b1; r = 32'(lo & mask);
    end else begin
      ov = 1'b0; r = 32'(p & mask);
    end
    return {ov, r};
  endfunction

  function automatic string tag_of(int n, bit md, longint a, longint b,
                                   logic [32:0] e);
    longint mn;
    mn = longint'(1) << (n - 1);
    if (a == 0 || b == 0) return "R6";
    if (md && a == mn && (b == 1 || b == (longint'(1) << n) - 1)) return "R7";
    if (!md) return e[32] ? "R2" : "R1";
    if (!e[32]) return "R3";
    return e[n-1] ? "R5" : "R4";
  endfunction

  task automatic check(string tag, longint got, longint exp, string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic run_big(bit md, longint a, longint b);
    logic [32:0] e;
    string t;
    @(posedge clk);
    a_b = NB'(a); b_b = NB'(b); m_b = md;
    @(negedge clk);
    e = ref_sat(NB, md, a, b);
    t = tag_of(NB, md, a, b, e);
    check(t, longint'(p_b), longint'(e[NB-1:0]), "product N=16");
    check((t == "R6" || t == "R7") ? t : "R8", longint'(o_b), longint'(e[32]),
          "flag N=16");
  endtask

  task automatic run_small(bit md, longint a, longint b);
    logic [32:0] e;
    string t;
    @(posedge clk);
    a_s = NS'(a); b_s = NS'(b); m_s = md;
    @(negedge clk);
    e = ref_sat(NS, md, a, b);
    t = tag_of(NS, md, a, b, e);
    check(t, longint'(p_s), longint'(e[NS-1:0]), "product N=4");
    check("R8", longint'(o_s), longint'(e[32]), "flag N=4");
  endtask

  function automatic longint sized_rand(int bits);
    longint v;
    v = longint'($urandom()) & ((longint'(1) << NB) - 1);
    if (bits < NB) v = v & ((longint'(1) << bits) - 1);
    return v;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    longint mn, mx;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    a_b = '0; b_b = '0; m_b = 1'b0;
    a_s = '0; b_s = '0; m_s = 1'b0;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle state with zero operands (R6)
    check("R6", longint'(p_b), 0, "idle product");
    check("R6", longint'(o_b), 0, "idle flag");
    rst_n = 1'b1;

    mn = longint'(1) << (NB - 1);
    mx = (longint'(1) << NB) - 1;
    // directed corners
    run_big(1'b1, mn, mx);          // R7 min * -1
    run_big(1'b1, mn, 1);           // R7 min * 1
    run_big(1'b1, mn, mn);          // R4 min * min
    run_big(1'b1, mn, 2);           // R5
    run_big(1'b1, mn - 1, mn - 1);  // R4 max * max
    run_big(1'b1, mn - 1, mx);      // R3 max * -1
    run_big(1'b0, mx, mx);          // R2
    run_big(1'b0, mx, 1);           // R1
    run_big(1'b0, 256, 256);        // R2 exactly 2^N
    run_big(1'b0, 255, 257);        // R1 just below 2^N
    run_big(1'b0, 0, mx);           // R6
    run_big(1'b1, mx, 0);           // R6 negative times zero
    run_big(1'b1, 0, mn);           // R6

    // exhaustive small width, both modes
    for (int md = 0; md < 2; md++)
      for (int a = 0; a < (1 << NS); a++)
        for (int b = 0; b < (1 << NS); b++)
          run_small(bit'(md), longint'(a), longint'(b));

    // random large width, sizes clustered near the thresholds
    for (int i = 0; i < 3000; i++) begin
      int ba, bb;
      ba = 1 + int'($urandom_range(NB - 1));
      bb = NB + 1 + int'($urandom_range(3)) - ba;
      if (bb > NB) bb = NB;
      if (bb < 1) bb = 1;
      if (($urandom() & 3) == 0) begin
        ba = NB; bb = NB;
      end
      run_big(bit'($urandom() & 1), sized_rand(ba), sized_rand(bb));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule